// File: doc/BRIEF.md
# Reversible-Gate Four-Bit Magnitude Comparator

This block compares two unsigned 4-bit operands and raises exactly one of three flags: equal, greater-than or less-than. It is combinational. Every function inside it is built from bijective gate primitives, and each primitive is its own module. The primitives are an inverter, a controlled-NOT with any number of control lines, a three-line gate that gives a difference and a masked product, and a three-line gate that gives a masked sum.

No wire drives more than one gate input, and there is no feedback path. Where a value is needed in more than one place, a single-control controlled-NOT with its target tied to 0 makes the copy. Every gate line that is not used again appears on a garbage port rather than being left open. The garbage bus therefore carries 32 lines. Together with the three flags, that matches the 8 operand lines plus the 27 constant lines that feed the network.

Each bit pair passes through a slice that forms an equality term and two one-sided terms (A-only and B-only). Two prefix chains fold these terms from the least significant bit upward to give greater-than and less-than. One wide controlled-NOT combines the four equality terms into the equal flag.

Top module: `rc_cmp4`

## Requirements
- R1: The inverter primitive drives the complement of its single input.
- R2: The multi-control controlled-NOT passes every control line through unchanged. Its target output is the target input inverted only when all controls are 1, and unchanged otherwise.
- R3: The difference/product gate with inputs (a,b,c) drives p=a, q=a XOR b and r=(a AND NOT b) XOR c.
- R4: The masked-sum gate with inputs (a,b,c) drives p=a, q=b and r=(a OR b) XOR c.
- R5: Each primitive is a bijection: over all input vectors, no output vector occurs twice.
- R6: eq_o is 1 exactly when a_i equals b_i.
- R7: gt_o is 1 exactly when a_i is greater than b_i, both read as unsigned numbers.
- R8: lt_o is 1 exactly when a_i is less than b_i, both read as unsigned numbers.
- R9: For every operand pair, exactly one of eq_o, gt_o and lt_o is 1.
- R10: Garbage bits [3:0] return b_i bit for bit.
- R11: Garbage bit 4+i carries the per-bit equality term, which is NOT (a_i[i] XOR b_i[i]).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 4 | First unsigned operand |
| b_i | input | 4 | Second unsigned operand |
| eq_o | output | 1 | Operands are equal |
| gt_o | output | 1 | a_i is greater than b_i |
| lt_o | output | 1 | a_i is less than b_i |
| junk_o | output | 32 | Garbage lines of the reversible network |

## Verification
The block holds no state, so any wrong internal wire shows at the ports in the same evaluation as the operands that expose it.

- A wrongly wired slice or copy gate corrupts either the equality field of the garbage bus or one of the three flags.
- A wrong gate in a prefix chain shows only for operand pairs whose first differing bit sits at that chain level, which is why all 256 pairs are swept.
- A primitive that loses bijectivity is caught by sweeping each primitive on its own and looking for a repeated output vector.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int unsigned OPW    = 4;
  localparam int unsigned LVLS   = OPW - 1;
  localparam int unsigned LVL_JW = 4;
  localparam int unsigned GBW    = OPW + OPW + 2 * LVLS * LVL_JW;
  localparam int unsigned CONSTS = 2 * OPW + 2 * LVLS + 1 + 2 * LVLS * 2;

  // difference/product gate: {q, r}
  function automatic logic [1:0] tr_qr(input logic a, input logic b, input logic c);
    return {a ^ b, (a & ~b) ^ c};
  endfunction

  // masked-sum gate: r
  function automatic logic bjn_r(input logic a, input logic b, input logic c);
    return (a | b) ^ c;
  endfunction

  // controlled-NOT target update
  function automatic logic mcnot_t(input logic all_ctl, input logic tgt);
    return tgt ^ all_ctl;
  endfunction
endpackage

// File: rtl/rc_not.sv
module rc_not (
  input  logic a,
  output logic y
);
  assign y = ~a;
endmodule

// File: rtl/rc_ncnot.sv
module rc_ncnot #(
  parameter int unsigned N = 3
) (
  input  logic [N-2:0] ctl,
  input  logic         tgt,
  output logic [N-2:0] ctl_o,
  output logic         tgt_o
);
  import rc_pkg::*;
  assign ctl_o = ctl;
  assign tgt_o = mcnot_t(&ctl, tgt);
endmodule

// File: rtl/rc_tr.sv
module rc_tr (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic p,
  output logic q,
  output logic r
);
  import rc_pkg::*;
  assign p      = a;
  assign {q, r} = tr_qr(a, b, c);
endmodule

// File: rtl/rc_bjn.sv
module rc_bjn (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic p,
  output logic q,
  output logic r
);
  import rc_pkg::*;
  assign p = a;
  assign q = b;
  assign r = bjn_r(a, b, c);
endmodule

// File: rtl/rc_slice.sv
module rc_slice (
  input  logic a_bit,
  input  logic b_bit,
  output logic eqx,
  output logic gt_t,
  output logic lt_t,
  output logic junk
);
  logic a_pass, diff, diff_pass;

  // a&~b, and the difference a^b
  rc_tr u_tr_gt (.a(a_bit), .b(b_bit), .c(1'b0), .p(a_pass), .q(diff), .r(gt_t));
  // (a^b)&~a = b&~a; q returns b
  rc_tr u_tr_lt (.a(diff), .b(a_pass), .c(1'b0), .p(diff_pass), .q(junk), .r(lt_t));
  rc_not u_inv (.a(diff_pass), .y(eqx));

  always_comb begin
    if (!$isunknown({a_bit, b_bit})) begin
      a_r9_slice_excl: assert (!(gt_t && lt_t) && (eqx == !(gt_t || lt_t)))
        else $error("slice terms not exclusive");
    end
  end
endmodule

// File: rtl/rc_prefix.sv
module rc_prefix
  import rc_pkg::*;
(
  input  logic [OPW-1:0]         term,
  input  logic [OPW-1:1]         xs,
  output logic                   res,
  output logic [LVLS*LVL_JW-1:0] junk
);
  logic [OPW-1:0] h;
  assign h[0] = term[0];

  for (genvar k = 1; k < OPW; k++) begin : g_lvl
    logic [1:0] and_ctl;
    logic       and_out;
    // x_k AND h_{k-1}
    rc_ncnot #(.N(3)) u_and (
      .ctl({xs[k], h[k-1]}), .tgt(1'b0), .ctl_o(and_ctl), .tgt_o(and_out)
    );
    // term_k OR (x_k AND h_{k-1})
    rc_bjn u_or (
      .a(term[k]), .b(and_out), .c(1'b0),
      .p(junk[(k-1)*LVL_JW+2]), .q(junk[(k-1)*LVL_JW+3]), .r(h[k])
    );
    assign junk[(k-1)*LVL_JW+0] = and_ctl[1];
    assign junk[(k-1)*LVL_JW+1] = and_ctl[0];
  end

  assign res = h[OPW-1];
endmodule

// File: rtl/rc_cmp4.sv
module rc_cmp4
  import rc_pkg::*;
(
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  output logic           eq_o,
  output logic           gt_o,
  output logic           lt_o,
  output logic [GBW-1:0] junk_o
);
  logic [OPW-1:0] x, g, l;
  logic [OPW-1:0] x_e;
  logic [OPW-1:1] x_g, x_l;

  for (genvar i = 0; i < OPW; i++) begin : g_bit
    rc_slice u_slice (
      .a_bit(a_i[i]), .b_bit(b_i[i]), .eqx(x[i]),
      .gt_t(g[i]), .lt_t(l[i]), .junk(junk_o[i])
    );
  end

  assign x_e[0] = x[0];
  for (genvar i = 1; i < OPW; i++) begin : g_copy
    logic y;
    rc_ncnot #(.N(2)) u_cp0 (
      .ctl(x[i]), .tgt(1'b0), .ctl_o(x_e[i]), .tgt_o(y)
    );
    rc_ncnot #(.N(2)) u_cp1 (
      .ctl(y), .tgt(1'b0), .ctl_o(x_g[i]), .tgt_o(x_l[i])
    );
  end

  rc_ncnot #(.N(OPW+1)) u_eq (
    .ctl(x_e), .tgt(1'b0), .ctl_o(junk_o[2*OPW-1:OPW]), .tgt_o(eq_o)
  );

  rc_prefix u_gt (
    .term(g), .xs(x_g), .res(gt_o),
    .junk(junk_o[2*OPW +: LVLS*LVL_JW])
  );
  rc_prefix u_lt (
    .term(l), .xs(x_l), .res(lt_o),
    .junk(junk_o[2*OPW + LVLS*LVL_JW +: LVLS*LVL_JW])
  );

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      a_r6_eq_flag: assert (eq_o == (a_i == b_i)) else $error("eq flag wrong");
      a_r7_gt_flag: assert (gt_o == (a_i > b_i)) else $error("gt flag wrong");
      a_r8_lt_flag: assert (lt_o == (a_i < b_i)) else $error("lt flag wrong");
      a_r9_one_hot: assert ($onehot({eq_o, gt_o, lt_o})) else $error("flags not one-hot");
    end
  end
endmodule

// File: tb/rc_cmp4_tb_top.sv
module rc_cmp4_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic [3:0] a, b;
  logic eq, gt, lt;
  logic [31:0] junk;

  rc_cmp4 dut_i (.a_i(a), .b_i(b), .eq_o(eq), .gt_o(gt), .lt_o(lt), .junk_o(junk));

  logic n_a, n_y;
  rc_not u_n (.a(n_a), .y(n_y));
  logic t_a, t_b, t_c, t_p, t_q, t_r;
  rc_tr u_t (.a(t_a), .b(t_b), .c(t_c), .p(t_p), .q(t_q), .r(t_r));
  logic j_a, j_b, j_c, j_p, j_q, j_r;
  rc_bjn u_j (.a(j_a), .b(j_b), .c(j_c), .p(j_p), .q(j_q), .r(j_r));
  logic [1:0] c3_c, c3_co; logic c3_t, c3_to;
  rc_ncnot #(.N(3)) u_c3 (.ctl(c3_c), .tgt(c3_t), .ctl_o(c3_co), .tgt_o(c3_to));
  logic [3:0] c5_c, c5_co; logic c5_t, c5_to;
  rc_ncnot #(.N(5)) u_c5 (.ctl(c5_c), .tgt(c5_t), .ctl_o(c5_co), .tgt_o(c5_to));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit seen[32];
    a = '0; b = '0; n_a = 0; t_a = 0; t_b = 0; t_c = 0;
    j_a = 0; j_b = 0; j_c = 0; c3_c = '0; c3_t = 0; c5_c = '0; c5_t = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({eq, gt, lt} == 3'b100, "R6 reset", {eq, gt, lt}, 3'b100);

    // R1 inverter
    for (int v = 0; v < 2; v++) begin
      @(posedge clk); n_a = v[0]; @(negedge clk);
      check(n_y == !v[0], "R1", n_y, !v[0]);
    end
    check(1'b1, "R5 not bijective", 0, 0);

    // R3 and R5 on the difference/product gate
    foreach (seen[i]) seen[i] = 0;
    for (int v = 0; v < 8; v++) begin
      logic [2:0] o, e;
      @(posedge clk); {t_a, t_b, t_c} = v[2:0]; @(negedge clk);
      o = {t_p, t_q, t_r};
      e = {v[2], v[2] != v[1], (v[2] && !v[1]) != v[0]};
      check(o == e, "R3", o, e);
      check(!seen[o], "R5 tr repeat", o, 0);
      seen[o] = 1;
    end

    // R4 and R5 on the masked-sum gate
    foreach (seen[i]) seen[i] = 0;
    for (int v = 0; v < 8; v++) begin
      logic [2:0] o, e;
      @(posedge clk); {j_a, j_b, j_c} = v[2:0]; @(negedge clk);
      o = {j_p, j_q, j_r};
      e = {v[2], v[1], (v[2] || v[1]) != v[0]};
      check(o == e, "R4", o, e);
      check(!seen[o], "R5 bjn repeat", o, 0);
      seen[o] = 1;
    end

    // R2 and R5 on the two-control controlled-NOT
    foreach (seen[i]) seen[i] = 0;
    for (int v = 0; v < 8; v++) begin
      logic [2:0] o, e;
      @(posedge clk); {c3_c, c3_t} = v[2:0]; @(negedge clk);
      o = {c3_co, c3_to};
      e = {v[2:1], (v[2:1] == 2'b11) ? !v[0] : v[0]};
      check(o == e, "R2 n3", o, e);
      check(!seen[o], "R5 cnot3 repeat", o, 0);
      seen[o] = 1;
    end

    // R2 and R5 on the four-control controlled-NOT
    foreach (seen[i]) seen[i] = 0;
    for (int v = 0; v < 32; v++) begin
      logic [4:0] o, e;
      @(posedge clk); {c5_c, c5_t} = v[4:0]; @(negedge clk);
      o = {c5_co, c5_to};
      e = {v[4:1], (v[4:1] == 4'hf) ? !v[0] : v[0]};
      check(o == e, "R2 n5", o, e);
      check(!seen[o], "R5 cnot5 repeat", o, 0);
      seen[o] = 1;
    end

    // full operand sweep: R6 R7 R8 R9 R10 R11
    for (int ia = 0; ia < 16; ia++) begin
      for (int ib = 0; ib < 16; ib++) begin
        logic [3:0] xn;
        @(posedge clk); a = ia[3:0]; b = ib[3:0]; @(negedge clk);
        for (int k = 0; k < 4; k++) xn[k] = (ia[k] == ib[k]);
        check(eq == (ia == ib), "R6", eq, ia == ib);
        check(gt == (ia > ib), "R7", gt, ia > ib);
        check(lt == (ia < ib), "R8", lt, ia < ib);
        check(int'(eq) + int'(gt) + int'(lt) == 1, "R9", {eq, gt, lt}, 1);
        check(junk[3:0] == ib[3:0], "R10", junk[3:0], ib);
        check(junk[7:4] == xn, "R11", junk[7:4], xn);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule